// File: doc/BRIEF.md
# Configurable Row-to-Row Pipeline Fabric

This block is the register fabric that sits between the rows of an eight-row combinational processing array. An input register loads operands into the first row. Each row's result then flows to the next row through a bank that either retimes it by one clock or lets it pass straight through. An output register captures the result of the last row. A static configuration word holds one bit per bank, so any subset of the seven banks may be active. The latency of the array therefore ranges from zero to seven clocks on top of the input and output registers. A bank that is switched off has its clock enable removed, so its contents freeze and it draws no switching power.

A valid token travels beside the data through the same retimed and bypassed stages. It marks the cycle in which the output register holds a fresh result. The block also reports how many banks are active. Results can also be handed from a row to the row before it, against the main flow; this return path is never retimed.

The configuration is meant to change only while the array is idle. Any change still empties the array, so no stale token can appear at the output.

Top module: `rowpipe_fabric`

## Requirements
- R1: After reset, `out_valid_o` is 0, the applied configuration is all zeros and `depth_o` is 0.
- R2: When applied configuration bit k is 0 (bit 0 is the bank between row 0 and row 1), row k+1's operand on `row_arg_o` equals row k's result on `row_res_i` in the same cycle.
- R3: When applied configuration bit k is 1, row k+1's operand equals the value row k's result had in the previous cycle.
- R4: A sample presented with `in_valid_i` high before clock edge t produces `out_valid_o` high after edge t+1+N, where N is the number of applied 1 bits. `out_data_o` then equals row 7's result for that sample.
- R5: `out_valid_o` is high for one cycle per sample, and `out_data_o` is unchanged in any cycle where `out_valid_o` is low.
- R6: A bank whose applied bit is 0 keeps its stored value. When it is enabled again, it first presents the value it held when it was last disabled.
- R7: When `cfg_i` differs from the applied configuration, the applied configuration takes the new value at the next edge. At that same edge every valid token is discarded, including any sample offered in that cycle and any sample still in flight.
- R8: `depth_o` equals the number of 1 bits in the applied configuration.
- R9: The return path is never registered. Row k's return operand (slice k of `ret_arg_o`) equals slice k of `ret_res_i`, which is row k+1's return result. Row 7's return operand is zero.
- R10: Row 0's operand is the input register, which loads `in_data_i` only at edges where `in_valid_i` is high and no configuration change is pending. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 7 | Bank enable per bank (bit k: bank after row k) |
| in_valid_i | input | 1 | Sample offered to the input register |
| in_data_i | input | 16 | Sample data |
| row_arg_o | output | 128 | Operand for each row, row k in bits [16k+15:16k] |
| row_res_i | input | 128 | Combinational result of each row, same packing |
| ret_res_i | input | 112 | Return-path result of rows 1 to 7, slice k from row k+1 |
| ret_arg_o | output | 128 | Return-path operand for each row |
| out_valid_o | output | 1 | Output register holds a new result this cycle |
| out_data_o | output | 16 | Output register |
| depth_o | output | 3 | Number of active banks |

## Verification
R6 is the hardest requirement to reach. A frozen bank is invisible while it is bypassed, so its hold behaviour can only be seen in the single cycle after it is switched back on. The stimulus first enables one mid-array bank so that it settles on a value derived from a known sample. It then bypasses the bank and runs a different sample through it. Finally it re-enables the bank and compares the next row's operand against the first sample's value. A second corner case is a configuration change while a token is still inside a seven-stage pipe. The token must then never reach the output.

// File: rtl/rowpipe_fabric.sv
module rowpipe_fabric #(
  parameter int ROWS = 8,
  parameter int W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ROWS-2:0]       cfg_i,
  input  logic                  in_valid_i,
  input  logic [W-1:0]          in_data_i,
  output logic [ROWS*W-1:0]     row_arg_o,
  input  logic [ROWS*W-1:0]     row_res_i,
  input  logic [(ROWS-1)*W-1:0] ret_res_i,
  output logic [ROWS*W-1:0]     ret_arg_o,
  output logic                  out_valid_o,
  output logic [W-1:0]          out_data_o,
  output logic [$clog2(ROWS)-1:0] depth_o
);
  localparam int NB = ROWS - 1;
  localparam int DW = $clog2(ROWS);

  logic [NB-1:0]        cfg_q;
  logic                 flush;
  logic                 fetch_v;
  logic [W-1:0]         fetch_d;
  logic [NB-1:0][W-1:0] stg_d;
  logic [NB-1:0]        stg_v;
  logic [ROWS-1:0][W-1:0] arg;
  logic [ROWS-1:0]      argv;

  assign flush   = (cfg_i != cfg_q);
  assign depth_o = DW'($countones(cfg_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      fetch_v <= 1'b0;
      fetch_d <= '0;
    end else begin
      cfg_q   <= cfg_i;
      fetch_v <= in_valid_i && !flush;
      if (in_valid_i && !flush) fetch_d <= in_data_i;
    end
  end

  assign arg[0]  = fetch_d;
  assign argv[0] = fetch_v;

  for (genvar k = 0; k < NB; k++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_d[k] <= '0;
        stg_v[k] <= 1'b0;
      end else begin
        if (cfg_q[k]) stg_d[k] <= row_res_i[k*W +: W];
        if (flush)         stg_v[k] <= 1'b0;
        else if (cfg_q[k]) stg_v[k] <= argv[k];
      end
    end
    assign arg[k+1]  = cfg_q[k] ? stg_d[k] : row_res_i[k*W +: W];
    assign argv[k+1] = cfg_q[k] ? stg_v[k] : argv[k];
    assign ret_arg_o[k*W +: W] = ret_res_i[k*W +: W];
  end

  assign ret_arg_o[NB*W +: W] = '0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_arg_o[r*W +: W] = arg[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= argv[ROWS-1] && !flush;
      if (argv[ROWS-1] && !flush) out_data_o <= row_res_i[(ROWS-1)*W +: W];
    end
  end
endmodule

module rowpipe_fabric_chk #(
  parameter int NB = 7,
  parameter int W  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NB-1:0]        cfg_i,
  input logic [NB-1:0]        cfg_q,
  input logic                 in_valid_i,
  input logic                 out_valid_o,
  input logic [W-1:0]         out_data_o,
  input logic [NB-1:0][W-1:0] stg_d
);
  // R7
  flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i != cfg_q) |=> !out_valid_o);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> $stable(out_data_o));

  // R4
  zero_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && cfg_q == '0 && cfg_i == '0) ##1 (cfg_i == '0) |=> out_valid_o);

  for (genvar k = 0; k < NB; k++) begin : g_hold
    // R6
    bank_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[k] |=> $stable(stg_d[k]));
  end
endmodule

bind rowpipe_fabric rowpipe_fabric_chk #(.NB(ROWS-1), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .cfg_q(cfg_q),
  .in_valid_i(in_valid_i), .out_valid_o(out_valid_o),
  .out_data_o(out_data_o), .stg_d(stg_d));

// File: tb/tb_rowpipe_fabric.sv
module tb_rowpipe_fabric;
  localparam int ROWS = 8;
  localparam int W    = 16;
  localparam int NB   = ROWS - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] cfg = '0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [ROWS*W-1:0] row_arg, row_res, ret_arg;
  logic [NB*W-1:0] ret_res = '0;
  logic out_valid;
  logic [W-1:0] out_data;
  logic [2:0] depth;

  always #2 clk = ~clk;

  rowpipe_fabric #(.ROWS(ROWS), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .in_valid_i(in_valid),
    .in_data_i(in_data), .row_arg_o(row_arg), .row_res_i(row_res),
    .ret_res_i(ret_res), .ret_arg_o(ret_arg), .out_valid_o(out_valid),
    .out_data_o(out_data), .depth_o(depth));

  for (genvar k = 0; k < ROWS; k++) begin : g_rowmodel
    assign row_res[k*W +: W] = row_arg[k*W +: W] + W'(k + 1);
  end

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  logic [NB-1:0] mcfg = '0;
  int due_q[$];
  logic [W-1:0] val_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [W-1:0] rarg(input int r);
    return row_arg[r*W +: W];
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && cfg != mcfg) begin
      mcfg <= cfg;
      due_q.delete();
      val_q.delete();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = (due_q.size() > 0) && (due_q[0] == cyc);
      chk(out_valid == ev, "R4/R5 out_valid", int'(out_valid), int'(ev));
      if (ev) begin
        chk(out_data == val_q[0], "R4 out_data", int'(out_data), int'(val_q[0]));
        void'(due_q.pop_front());
        void'(val_q.pop_front());
      end
      chk(depth == 3'($countones(mcfg)), "R8 depth", int'(depth), $countones(mcfg));
      for (int k = 0; k < NB; k++)
        chk(ret_arg[k*W +: W] == ret_res[k*W +: W], "R9 return path",
            int'(ret_arg[k*W +: W]), int'(ret_res[k*W +: W]));
      chk(ret_arg[NB*W +: W] == '0, "R9 last return zero", int'(ret_arg[NB*W +: W]), 0);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    ret_res = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic send(input logic [W-1:0] x);
    in_valid = 1'b1;
    in_data  = x;
    if (cfg == mcfg) begin
      due_q.push_back(cyc + 2 + $countones(mcfg));
      val_q.push_back(x + W'(36));
    end
    tick();
    in_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [NB-1:0] v);
    cfg = v;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    logic [NB-1:0] cfgs [6] = '{7'h00, 7'h7F, 7'h01, 7'h55, 7'h2A, 7'h40};
    logic [W-1:0] a, b;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    chk(depth == 3'd0, "R1 reset depth", int'(depth), 0);
    rst_n = 1'b1;
    tick();

    // R4 R5: several configurations, back-to-back and gapped samples
    foreach (cfgs[i]) begin
      set_cfg(cfgs[i]);
      idle(2);
      for (int s = 0; s < 4; s++) send(W'($urandom));
      idle(1);
      send(W'($urandom));
      idle(2);
      send(W'($urandom));
      idle(12);
    end

    // R2 R10: all bypassed, operand chain is combinational
    set_cfg('0);
    idle(1);
    a = 16'h1234;
    send(a);
    @(negedge clk);
    chk(rarg(0) == a, "R10 row0 operand", int'(rarg(0)), int'(a));
    chk(rarg(7) == a + W'(28), "R2 bypass chain", int'(rarg(7)), int'(a + W'(28)));
    idle(6);
    chk(rarg(0) == a, "R10 input holds", int'(rarg(0)), int'(a));

    // R3: bank 0 enabled delays by one cycle
    set_cfg(7'h01);
    idle(3);
    b = 16'h0F00;
    send(b);
    @(negedge clk);
    chk(rarg(1) == a + W'(1), "R3 old value before edge", int'(rarg(1)), int'(a + W'(1)));
    tick();
    @(negedge clk);
    chk(rarg(1) == b + W'(1), "R3 delayed value", int'(rarg(1)), int'(b + W'(1)));
    idle(10);

    // R6: frozen bank presents its held value when re-enabled
    set_cfg(7'h08);
    a = 16'h0500;
    send(a);
    idle(6);
    set_cfg('0);
    b = 16'h7000;
    send(b);
    idle(6);
    cfg = 7'h08;
    tick();
    @(negedge clk);
    chk(rarg(4) == a + W'(10), "R6 held bank value", int'(rarg(4)), int'(a + W'(10)));
    tick();
    @(negedge clk);
    chk(rarg(4) == b + W'(10), "R6 bank reloads", int'(rarg(4)), int'(b + W'(10)));
    idle(10);

    // R7: sample offered in the change cycle is dropped
    cfg = 7'h03;
    send(16'hAAAA);
    idle(12);
    chk(due_q.size() == 0, "R7 drop in change cycle", due_q.size(), 0);

    // R7: in-flight token discarded by a change
    set_cfg(7'h7F);
    idle(2);
    send(16'h4444);
    idle(2);
    set_cfg(7'h00);
    idle(12);
    send(16'h0101);
    idle(6);
    chk(due_q.size() == 0, "R7 pipe drained", due_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule